// File: doc/BRIEF.md
# Keypad port pin controller

This block sits between a small register bus and sixteen keypad pads. The upper eight pins (15:8) serve the keypad columns and the lower eight (7:0) serve the rows. Each pad is represented by three signals: the value to drive, an enable for that drive, and the level seen on the pad. Software picks, pin by pin, whether the pin listens or drives. For column pins it can also pick between a full push-pull driver and an open-drain driver that only ever pulls low. Row pins always drive push-pull when they are outputs.

Four halfword registers hold the column drive style, a free status word, the pin directions and the output latch. A read of the data register returns a mix: the latch value for pins that drive, and the synchronized pad level for pins that listen. Key scanning, debouncing and interrupts are left to software or to a neighbouring block.

Top module: `kpad_port`

## Requirements
- R1: After reset, the drive-style, status and direction registers read 0x0000, every pad_oe bit is 0 and every pad_out bit is 0.
- R2: A column pin (15:8) whose direction bit is 0 has pad_oe low, whatever its drive-style bit holds.
- R3: A column pin with direction 1 and drive-style 0 has pad_oe high and pad_out equal to its data-latch bit.
- R4: A column pin with direction 1 and drive-style 1 never drives pad_out high. It enables its driver (pad_oe=1, pad_out=0) when its latch bit is 0 and releases the pad (pad_oe=0) when its latch bit is 1, so the line reaches 1 only through the external pull-up.
- R5: A row pin (7:0) has pad_oe equal to its direction bit and, when enabled, pad_out equal to its latch bit. Drive-style bits 7:0 are not stored: they read back as 0 and have no effect on row pads.
- R6: bus_addr carries byte-offset bits 2:1 and selects the register: 0 drive style, 1 status, 2 direction, 3 data. A write with bus_wr high takes effect at the rising clock edge that samples it, and not before. Reads are combinational from bus_addr.
- R7: The status register stores any 16-bit value written and returns it on read, with no effect on any pad signal.
- R8: A read of the data register returns the latch bit for pins with direction 1 and the pad level for pins with direction 0. The pad level passes through a two-flop synchronizer: a level change made between two edges is seen by a read after the second rising edge that follows the change, and not after the first.
- R9: Whenever a pin's pad_oe is 0, its pad_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select, byte-offset bits 2:1 |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| pad_in | input | 16 | Level present on each pad |
| pad_out | output | 16 | Value driven on each pad |
| pad_oe | output | 16 | Drive enable for each pad |

## Verification
The hardest situation to reach is a released open-drain column that reads high only because of the pull-up. It has to be told apart from a column that drives high actively. The bench models every pad line with a pull-up and an optional external driver, and it looks at pad_oe, pad_out and the resolved line separately. Random mixes of direction, drive style and latch value put released, driven-low, push-pull and input columns side by side in the same pattern. A directed step changes an input level between edges and reads the data register after one edge and again after two, which pins down the synchronizer delay.

// File: rtl/kpad_port_pkg.sv
package kpad_port_pkg;

   // Register select, taken from byte-offset bits 2:1 of the bus address.
   typedef enum logic [1:0] {
      REG_DRV  = 2'd0,
      REG_STAT = 2'd1,
      REG_DIR  = 2'd2,
      REG_DATA = 2'd3
   } kp_reg_e;

endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/kpad_regs.sv
module kpad_regs
   import kpad_port_pkg::*;
#(
   parameter int COL_W = 8,
   parameter int ROW_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               sel_idx,
   input  logic                     wr,
   input  logic [COL_W+ROW_W-1:0]   wdata,
   input  logic [COL_W+ROW_W-1:0]   pin_lvl,
   output logic [COL_W+ROW_W-1:0]   rdata,
   output logic [COL_W-1:0]         drv_q,
   output logic [COL_W+ROW_W-1:0]   dir_q,
   output logic [COL_W+ROW_W-1:0]   dat_q
);

   localparam int PW = COL_W + ROW_W;

   kp_reg_e          sel;
   logic [PW-1:0]    stat_q;

   assign sel = kp_reg_e'(sel_idx);

   // Control state: comes out of reset with every pin listening.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q  <= '0;
         stat_q <= '0;
         dir_q  <= '0;
      end else if (wr) begin
         case (sel)
            REG_DRV:  drv_q  <= wdata[PW-1 -: COL_W];
            REG_STAT: stat_q <= wdata;
            REG_DIR:  dir_q  <= wdata;
            default:  ;
         endcase
      end
   end

   // Output latch has no defined reset value.
   always_ff @(posedge clk) begin
      if (wr && sel == REG_DATA) dat_q <= wdata;
   end

   always_comb begin
      case (sel)
         REG_DRV:  rdata = {drv_q, {ROW_W{1'b0}}};
         REG_STAT: rdata = stat_q;
         REG_DIR:  rdata = dir_q;
         default:  rdata = (dir_q & dat_q) | (~dir_q & pin_lvl);
      endcase
   end

endmodule

// File: rtl/kpad_pad_drv.sv
module kpad_pad_drv #(
   parameter int COL_W = 8,
   parameter int ROW_W = 8
) (
   input  logic [COL_W-1:0]       drv,
   input  logic [COL_W+ROW_W-1:0] dir,
   input  logic [COL_W+ROW_W-1:0] dat,
   output logic [COL_W+ROW_W-1:0] o,
   output logic [COL_W+ROW_W-1:0] oe
);

   localparam int PW = COL_W + ROW_W;

   for (genvar i = 0; i < PW; i++) begin : g_pin
      if (i >= ROW_W) begin : g_col
         localparam int C = i - ROW_W;
         // Open-drain: drive only a low, release the pad for a one.
         assign oe[i] = dir[i] & ~(drv[C] & dat[i]);
         assign o[i]  = dir[i] & ~drv[C] & dat[i];
      end else begin : g_row
         assign oe[i] = dir[i];
         assign o[i]  = dir[i] & dat[i];
      end
   end

endmodule

// File: rtl/kpad_port.sv
module kpad_port #(
   parameter int COL_W       = 8,
   parameter int ROW_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:1]             bus_addr,
   input  logic                   bus_wr,
   input  logic [COL_W+ROW_W-1:0] bus_wdata,
   output logic [COL_W+ROW_W-1:0] bus_rdata,
   input  logic [COL_W+ROW_W-1:0] pad_in,
   output logic [COL_W+ROW_W-1:0] pad_out,
   output logic [COL_W+ROW_W-1:0] pad_oe
);

   localparam int PW = COL_W + ROW_W;

   if (COL_W < 1 || ROW_W < 1) begin : g_bad_width
      $error("kpad_port: COL_W and ROW_W must both be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("kpad_port: SYNC_STAGES must be at least 2");
   end

   logic [PW-1:0]    pin_lvl;
   logic [COL_W-1:0] drv_q;
   logic [PW-1:0]    dir_q;
   logic [PW-1:0]    dat_q;

   kpad_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_lvl)
   );

   kpad_regs #(.COL_W(COL_W), .ROW_W(ROW_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_idx (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .pin_lvl (pin_lvl),
      .rdata   (bus_rdata),
      .drv_q   (drv_q),
      .dir_q   (dir_q),
      .dat_q   (dat_q)
   );

   kpad_pad_drv #(.COL_W(COL_W), .ROW_W(ROW_W)) u_drv (
      .drv (drv_q),
      .dir (dir_q),
      .dat (dat_q),
      .o   (pad_out),
      .oe  (pad_oe)
   );

endmodule

// File: rtl/kpad_port_chk.sv
module kpad_port_chk #(
   parameter int COL_W       = 8,
   parameter int ROW_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [2:1]             bus_addr,
   input logic                   bus_wr,
   input logic [COL_W+ROW_W-1:0] bus_wdata,
   input logic [COL_W+ROW_W-1:0] bus_rdata,
   input logic [COL_W+ROW_W-1:0] pad_in,
   input logic [COL_W+ROW_W-1:0] pad_out,
   input logic [COL_W+ROW_W-1:0] pad_oe,
   input logic [COL_W-1:0]       drv_q,
   input logic [COL_W+ROW_W-1:0] dir_q,
   input logic [COL_W+ROW_W-1:0] dat_q
);

   localparam int PW = COL_W + ROW_W;

   // Edges seen since reset, saturating once the synchronizer is full.
   int unsigned since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        since_rst <= 0;
      else if (since_rst < SYNC_STAGES)  since_rst <= since_rst + 1;
   end

   assert_undriven_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   assert_dir_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2) |=> dir_q == $past(bus_wdata));

   for (genvar i = 0; i < PW; i++) begin : g_pin
      if (i >= ROW_W) begin : g_col
         assert_col_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !dir_q[i] |-> !pad_oe[i]);
         assert_col_pushpull_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_q[i] && !drv_q[i-ROW_W]) |-> (pad_oe[i] && pad_out[i] == dat_q[i]));
         assert_col_opendrain_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_q[i] && drv_q[i-ROW_W]) |-> (!pad_out[i] && pad_oe[i] == !dat_q[i]));
      end else begin : g_row
         assert_row_pushpull_R5: assert property (@(posedge clk) disable iff (!rst_n)
            dir_q[i] |-> (pad_oe[i] && pad_out[i] == dat_q[i]));
      end
      assert_input_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= SYNC_STAGES && bus_addr == 2'd3 && !dir_q[i])
            |-> bus_rdata[i] == $past(pad_in[i], SYNC_STAGES));
   end

endmodule

bind kpad_port kpad_port_chk #(
   .COL_W       (COL_W),
   .ROW_W       (ROW_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .drv_q     (drv_q),
   .dir_q     (dir_q),
   .dat_q     (dat_q)
);

// File: tb/kpad_port_tb.sv
`timescale 1ns/1ps
module kpad_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:1]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pad_in;
   logic [15:0] pad_out;
   logic [15:0] pad_oe;

   // External pad model: optional outside driver, pull-up otherwise.
   logic [15:0] ext_en = '0;
   logic [15:0] ext_val = '0;
   logic [15:0] line;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // Bench copy of the programmed state.
   logic [7:0]  m_drv = '0;
   logic [15:0] m_dir = '0;
   logic [15:0] m_dat = '0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 16; i++)
         line[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : 1'b1);
   end
   assign pad_in = line;

   kpad_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe)
   );

   function automatic logic [15:0] f_oe(logic [7:0] drv, logic [15:0] dir, logic [15:0] dat);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) begin
         if (!dir[i])                r[i] = 1'b0;
         else if (i < 8)             r[i] = 1'b1;
         else if (drv[i-8])          r[i] = (dat[i] == 1'b0);
         else                        r[i] = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [15:0] f_out(logic [7:0] drv, logic [15:0] dir, logic [15:0] dat);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) begin
         if (!dir[i])                r[i] = 1'b0;
         else if (i >= 8 && drv[i-8]) r[i] = 1'b0;
         else                        r[i] = dat[i];
      end
      return r;
   endfunction

   // Level each pad settles to, given the bench's drive and pull-up model.
   function automatic logic [15:0] f_line(logic [7:0] drv, logic [15:0] dir, logic [15:0] dat,
                                          logic [15:0] een, logic [15:0] eval);
      logic [15:0] oe = f_oe(drv, dir, dat);
      logic [15:0] o  = f_out(drv, dir, dat);
      logic [15:0] r;
      for (int i = 0; i < 16; i++)
         r[i] = oe[i] ? o[i] : (een[i] ? eval[i] : 1'b1);
      return r;
   endfunction

   function automatic logic [15:0] f_rd(logic [15:0] dir, logic [15:0] dat, logic [15:0] lvl);
      return (dir & dat) | (~dir & lvl);
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      case (a)
         2'd0: m_drv = d[15:8];
         2'd2: m_dir = d;
         2'd3: m_dat = d;
         default: ;
      endcase
   endtask

   task automatic rd_reg(logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_edges(int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   task automatic chk_pads(string tag);
      @(negedge clk);
      chk({tag, " oe"}, pad_oe, f_oe(m_drv, m_dir, m_dat));
      chk({tag, " out"}, pad_out, f_out(m_drv, m_dir, m_dat));
      chk({tag, " line"}, line, f_line(m_drv, m_dir, m_dat, ext_en, ext_val));
      chk("R9 undriven pads low", pad_out & ~pad_oe, 16'h0000);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      void'($urandom(32'd20240611));

      wait_edges(3);
      @(negedge clk);
      chk("R1 oe at reset", pad_oe, 16'h0000);
      chk("R1 out at reset", pad_out, 16'h0000);
      rst_n = 1'b1;
      rd_reg(2'd0, rd); chk("R1 drive-style reset", rd, 16'h0000);
      rd_reg(2'd1, rd); chk("R1 status reset", rd, 16'h0000);
      rd_reg(2'd2, rd); chk("R1 direction reset", rd, 16'h0000);

      // R6: the write shows up only at the sampling edge.
      wr_reg(2'd3, 16'h00FF);
      @(negedge clk);
      bus_addr = 2'd2; bus_wdata = 16'h00FF; bus_wr = 1'b1;
      #1 chk("R6 no effect before edge", pad_oe, 16'h0000);
      @(posedge clk);
      #1 chk("R6 effect after edge", pad_oe, 16'h00FF);
      @(negedge clk);
      bus_wr = 1'b0; m_dir = 16'h00FF;

      // R4: all columns open-drain with a mixed latch pattern.
      wr_reg(2'd0, 16'hFFFF);
      wr_reg(2'd3, 16'hA55A);
      wr_reg(2'd2, 16'hFF00);
      chk_pads("R4 open-drain columns");
      chk("R4 never drives high", pad_out[15:8], 8'h00);
      chk("R4 released lines pulled up", {8'h00, line[15:8]}, 16'h00A5);
      rd_reg(2'd3, rd); chk("R8 output pins read latch", rd[15:8], 8'hA5);

      // R2: direction 0 wins over drive style.
      wr_reg(2'd2, 16'h0000);
      chk_pads("R2 columns as inputs");
      chk("R2 columns undriven", pad_oe, 16'h0000);

      // R3: push-pull columns.
      wr_reg(2'd0, 16'h0000);
      wr_reg(2'd2, 16'hFF00);
      chk_pads("R3 push-pull columns");
      chk("R3 columns follow latch", {8'h00, pad_out[15:8]}, 16'h00A5);

      // R5: row drive-style bits are not stored and do not change rows.
      wr_reg(2'd0, 16'h00FF);
      rd_reg(2'd0, rd); chk("R5 row drive-style bits read zero", rd, 16'h0000);
      wr_reg(2'd2, 16'h00FF);
      wr_reg(2'd3, 16'h00FF);
      chk_pads("R5 rows push-pull");
      chk("R5 rows drive high actively", {8'h00, pad_oe[7:0]}, 16'h00FF);

      // R7: status round trip, pads untouched.
      wr_reg(2'd1, 16'h3C96);
      rd_reg(2'd1, rd); chk("R7 status read back", rd, 16'h3C96);
      chk_pads("R7 pads unchanged by status");

      // R8: synchronizer delay on an input pin.
      wr_reg(2'd2, 16'h0000);
      ext_en = 16'hFFFF; ext_val = 16'h1234;
      wait_edges(4);
      @(negedge clk);
      bus_addr = 2'd3;
      ext_val = 16'hEDCB;
      @(posedge clk);
      @(negedge clk);
      #1 chk("R8 old level after one edge", bus_rdata, 16'h1234);
      @(posedge clk);
      @(negedge clk);
      #1 chk("R8 new level after two edges", bus_rdata, 16'hEDCB);

      // Random mixes of every pin mode.
      for (int it = 0; it < 150; it++) begin
         logic [15:0] lvl;
         ext_en  = 16'($urandom());
         ext_val = 16'($urandom());
         wr_reg(2'd0, 16'($urandom()));
         wr_reg(2'd3, 16'($urandom()));
         wr_reg(2'd2, 16'($urandom()));
         wait_edges(3);
         chk_pads("R2 R3 R4 R5 random pads");
         lvl = f_line(m_drv, m_dir, m_dat, ext_en, ext_val);
         rd_reg(2'd3, rd);
         chk("R8 random data read", rd, f_rd(m_dir, m_dat, lvl));
         rd_reg(2'd0, rd);
         chk("R6 random drive-style read", rd, {m_drv, 8'h00});
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule